// File: doc/BRIEF.md
# Dual-Reset Configuration Register File

This block holds the configuration fields of a bridge that presents two functions to its host. Each function has a private copy of its own registers and sees one shared routing register that both functions read. Software reaches the fields through a simple register bus carrying a function number, a dword address into a 256-byte space per function, byte enables and write data. Read data comes back registered one cycle later. A hardware update port lets the surrounding logic raise event and power-management status bits in either function without a software write.

Every field has an access type and a reset class. The access type is read-only, plain write, write-1-to-set, or write-1-to-clear with hardware set. The reset class decides which reset clears it. Warm-class fields clear on either reset. Cold-only fields survive any warm reset. Power-context fields survive a warm reset only while that function's power-event enable bit is 1. The enable is itself a power-context field, so the decision follows the value it held before the warm reset.

Register map, by dword address: 0x00 identity (read-only, value `DEV_ID` with the function number in bits [7:0]); 0x01 control, bits [15:0], plain write, warm class; 0x02 events, bits [7:0] write-1-to-clear with hardware set, power-context class, and bits [23:16] write-1-to-set, warm class; 0x03 routing, bits [15:0], plain write, cold-only, shared by both functions; 0x29 power, bits [1:0] state (plain write, warm class), bit 8 power-event enable (plain write, power-context class), bit 15 power-event status (write-1-to-clear with hardware set, power-context class). All other bits and addresses read as zero.

Top module: `cfgrf_dualreset`

## Requirements
- R1: A read returns the addressed dword on `bus_rdata` at the clock edge after the request. The identity dword reads `DEV_ID` with the function number in bits [7:0], and writes to it change nothing.
- R2: Plain-write fields take the written value only in the bytes whose enable bit is 1. The `bus_be` bit n covers `bus_wdata` bits [8n+7:8n].
- R3: Write-1-to-set bits (events [23:16]) go to 1 where a 1 is written under an enabled byte. Writing 0 leaves them unchanged.
- R4: Write-1-to-clear bits (events [7:0], power bit 15) clear where a 1 is written and keep their value where a 0 is written. A 1 on `hw_evt` or `hw_pme` sets them only in the function named by `hw_func`. When a hardware set and a software clear hit the same bit in the same cycle, the bit ends up 1.
- R5: A cold reset clears every stored field in both functions, including the shared routing field.
- R6: A warm reset clears the control field, the set-only event bits and the power state bits whatever the enable setting.
- R7: On a warm reset, the power-context fields (event bits [7:0], power-event enable, power-event status) of a function clear if that function's enable bit is 0 and keep their value if it is 1.
- R8: The routing field keeps its value across a warm reset.
- R9: Only a write with function number 0 changes the routing field. A write with function number 1 is ignored. Both functions read the same routing value.
- R10: Unmapped addresses read as zero, and writes to them change no field.
- R11: A write issued in a cycle where either reset is asserted changes no field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_cold | input | 1 | Cold reset, synchronous, active high |
| rst_warm | input | 1 | Warm reset, synchronous, active high |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_func | input | FUNC_W | Target function number |
| bus_addr | input | 6 | Dword address inside the 256-byte space |
| bus_be | input | 4 | Byte enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| hw_func | input | FUNC_W | Function targeted by the hardware update |
| hw_evt | input | 8 | Hardware set strobes for event bits [7:0] |
| hw_pme | input | 1 | Hardware set strobe for the power-event status |

## Verification
The assertions assume that the bus carries at most one access per cycle. They also assume that hardware set strobes are raised outside reset whenever the assertions are expected to see their effect. Under these assumptions a frozen or preserved field can be judged by comparing consecutive cycles. The stimulus drives every access and strobe for exactly one cycle between falling edges. It asserts each reset for a single edge, and issues writes during a reset only in the scenario that checks they are discarded.

// File: rtl/cfgrf_pkg.sv
`timescale 1ns/1ps
package cfgrf_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;

  typedef enum logic [1:0] {ACC_W, ACC_S, ACC_C} acc_e;
  typedef enum logic [1:0] {RC_WARM, RC_PME, RC_COLD} rclass_e;

  localparam logic [ADDR_W-1:0] OFS_IDENT = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h01;
  localparam logic [ADDR_W-1:0] OFS_EVT   = 6'h02;
  localparam logic [ADDR_W-1:0] OFS_ROUTE = 6'h03;
  localparam logic [ADDR_W-1:0] OFS_PM    = 6'h29;

  localparam int CTRL_W   = 16;
  localparam int EVT_W    = 8;
  localparam int STK_W    = 8;
  localparam int STK_LSB  = 16;
  localparam int ROUTE_W  = 16;
  localparam int PMST_W   = 2;
  localparam int PMEN_BIT = 8;
  localparam int PMSTS_BIT = 15;
endpackage

// File: rtl/cfgrf_field.sv
`timescale 1ns/1ps
module cfgrf_field
  import cfgrf_pkg::*;
#(
  parameter int      W   = 8,
  parameter acc_e    ACC = ACC_W,
  parameter rclass_e RCL = RC_WARM
) (
  input  logic         clk,
  input  logic         rst_cold,
  input  logic         rst_warm,
  input  logic         pme_keep,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] wr_mask,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  logic         clr;
  logic [W-1:0] nxt;

  // Reset class decides which reset wipes the field.
  always_comb begin
    clr = rst_cold;
    if (rst_warm) begin
      if (RCL == RC_WARM) clr = 1'b1;
      else if (RCL == RC_PME && !pme_keep) clr = 1'b1;
    end
  end

  // A surviving field is frozen while warm reset is held.
  always_comb begin
    nxt = q;
    if (!rst_warm) begin
      case (ACC)
        ACC_W: if (wr_en) nxt = (q & ~wr_mask) | (wr_data & wr_mask);
        ACC_S: if (wr_en) nxt = q | (wr_data & wr_mask);
        ACC_C: begin
          if (wr_en) nxt = q & ~(wr_data & wr_mask);
          nxt = nxt | hw_set;
        end
        default: nxt = q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (clr) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/cfgrf_func.sv
`timescale 1ns/1ps
module cfgrf_func
  import cfgrf_pkg::*;
#(
  parameter int          FUNC_ID = 0,
  parameter logic [31:0] DEV_ID  = 32'h7A10_0000
) (
  input  logic                clk,
  input  logic                rst_cold,
  input  logic                rst_warm,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [DATA_W-1:0]   wr_mask,
  input  logic [EVT_W-1:0]    hw_evt,
  input  logic                hw_pme,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [ROUTE_W-1:0]  route_q,
  output logic [DATA_W-1:0]   rd_word,
  output logic                pme_en,
  output logic [EVT_W-1:0]    evt_q
);
  localparam logic [7:0] FID8 = 8'(FUNC_ID);

  logic we_ctrl, we_evt, we_pm;
  logic [CTRL_W-1:0] ctrl_q;
  logic [STK_W-1:0]  stk_q;
  logic [PMST_W-1:0] pmst_q;
  logic              pmsts_q;
  logic              unused_bits;

  assign we_ctrl = wr_en && (wr_addr == OFS_CTRL);
  assign we_evt  = wr_en && (wr_addr == OFS_EVT);
  assign we_pm   = wr_en && (wr_addr == OFS_PM);
  assign unused_bits = ^{wr_data, wr_mask};

  cfgrf_field #(.W(CTRL_W), .ACC(ACC_W), .RCL(RC_WARM)) u_ctrl (
    .clk(clk), .rst_cold(rst_cold), .rst_warm(rst_warm), .pme_keep(pme_en),
    .wr_en(we_ctrl), .wr_data(wr_data[CTRL_W-1:0]), .wr_mask(wr_mask[CTRL_W-1:0]),
    .hw_set('0), .q(ctrl_q));

  cfgrf_field #(.W(EVT_W), .ACC(ACC_C), .RCL(RC_PME)) u_evt (
    .clk(clk), .rst_cold(rst_cold), .rst_warm(rst_warm), .pme_keep(pme_en),
    .wr_en(we_evt), .wr_data(wr_data[EVT_W-1:0]), .wr_mask(wr_mask[EVT_W-1:0]),
    .hw_set(hw_evt), .q(evt_q));

  cfgrf_field #(.W(STK_W), .ACC(ACC_S), .RCL(RC_WARM)) u_stk (
    .clk(clk), .rst_cold(rst_cold), .rst_warm(rst_warm), .pme_keep(pme_en),
    .wr_en(we_evt), .wr_data(wr_data[STK_LSB +: STK_W]), .wr_mask(wr_mask[STK_LSB +: STK_W]),
    .hw_set('0), .q(stk_q));

  cfgrf_field #(.W(PMST_W), .ACC(ACC_W), .RCL(RC_WARM)) u_pmst (
    .clk(clk), .rst_cold(rst_cold), .rst_warm(rst_warm), .pme_keep(pme_en),
    .wr_en(we_pm), .wr_data(wr_data[PMST_W-1:0]), .wr_mask(wr_mask[PMST_W-1:0]),
    .hw_set('0), .q(pmst_q));

  // The enable gates its own warm clear: a 1 keeps it, a 0 stays 0.
  cfgrf_field #(.W(1), .ACC(ACC_W), .RCL(RC_PME)) u_pmen (
    .clk(clk), .rst_cold(rst_cold), .rst_warm(rst_warm), .pme_keep(pme_en),
    .wr_en(we_pm), .wr_data(wr_data[PMEN_BIT]), .wr_mask(wr_mask[PMEN_BIT]),
    .hw_set(1'b0), .q(pme_en));

  cfgrf_field #(.W(1), .ACC(ACC_C), .RCL(RC_PME)) u_pmsts (
    .clk(clk), .rst_cold(rst_cold), .rst_warm(rst_warm), .pme_keep(pme_en),
    .wr_en(we_pm), .wr_data(wr_data[PMSTS_BIT]), .wr_mask(wr_mask[PMSTS_BIT]),
    .hw_set(hw_pme), .q(pmsts_q));

  always_comb begin
    rd_word = '0;
    case (rd_addr)
      OFS_IDENT: rd_word = {DEV_ID[31:8], FID8};
      OFS_CTRL:  rd_word[CTRL_W-1:0] = ctrl_q;
      OFS_EVT: begin
        rd_word[EVT_W-1:0]         = evt_q;
        rd_word[STK_LSB +: STK_W]  = stk_q;
      end
      OFS_ROUTE: rd_word[ROUTE_W-1:0] = route_q;
      OFS_PM: begin
        rd_word[PMST_W-1:0] = pmst_q;
        rd_word[PMEN_BIT]   = pme_en;
        rd_word[PMSTS_BIT]  = pmsts_q;
      end
      default: rd_word = '0;
    endcase
  end
endmodule

// File: rtl/cfgrf_dualreset.sv
`timescale 1ns/1ps
module cfgrf_dualreset
  import cfgrf_pkg::*;
#(
  parameter int          NUM_FUNC = 2,
  parameter logic [31:0] DEV_ID   = 32'h7A10_0000,
  localparam int         FUNC_W   = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1
) (
  input  logic              clk,
  input  logic              rst_cold,
  input  logic              rst_warm,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [FUNC_W-1:0] bus_func,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [FUNC_W-1:0] hw_func,
  input  logic [EVT_W-1:0]  hw_evt,
  input  logic              hw_pme
);
  logic [DATA_W-1:0]       wmask;
  logic                    wr_ok;
  logic [ROUTE_W-1:0]      route_q;
  logic [DATA_W-1:0]       rd_word [NUM_FUNC];
  logic [NUM_FUNC-1:0]     pme_en_vec;
  logic [NUM_FUNC*EVT_W-1:0] evt_flat;
  logic                    unused_obs;

  assign wr_ok = bus_req && bus_we && !rst_cold && !rst_warm;
  assign unused_obs = ^{pme_en_vec, evt_flat};

  for (genvar b = 0; b < BE_W; b++) begin : g_mask
    assign wmask[b*8 +: 8] = {8{bus_be[b]}};
  end

  // Shared field: one copy, written only through function 0.
  cfgrf_field #(.W(ROUTE_W), .ACC(ACC_W), .RCL(RC_COLD)) u_route (
    .clk(clk), .rst_cold(rst_cold), .rst_warm(rst_warm), .pme_keep(1'b0),
    .wr_en(wr_ok && (bus_func == '0) && (bus_addr == OFS_ROUTE)),
    .wr_data(bus_wdata[ROUTE_W-1:0]), .wr_mask(wmask[ROUTE_W-1:0]),
    .hw_set('0), .q(route_q));

  for (genvar f = 0; f < NUM_FUNC; f++) begin : g_fn
    logic [EVT_W-1:0] f_evt;
    logic             f_pme;
    assign f_evt = (hw_func == FUNC_W'(f)) ? hw_evt : '0;
    assign f_pme = (hw_func == FUNC_W'(f)) && hw_pme;

    cfgrf_func #(.FUNC_ID(f), .DEV_ID(DEV_ID)) u_fn (
      .clk(clk), .rst_cold(rst_cold), .rst_warm(rst_warm),
      .wr_en(wr_ok && (bus_func == FUNC_W'(f))), .wr_addr(bus_addr),
      .wr_data(bus_wdata), .wr_mask(wmask),
      .hw_evt(f_evt), .hw_pme(f_pme),
      .rd_addr(bus_addr), .route_q(route_q),
      .rd_word(rd_word[f]), .pme_en(pme_en_vec[f]),
      .evt_q(evt_flat[f*EVT_W +: EVT_W]));
  end

  always_ff @(posedge clk) begin
    if (rst_cold || rst_warm) begin
      bus_rdata <= '0;
    end else if (bus_req && !bus_we) begin
      if (int'(bus_func) < NUM_FUNC) bus_rdata <= rd_word[bus_func];
      else                           bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/cfgrf_chk.sv
`timescale 1ns/1ps
module cfgrf_chk
  import cfgrf_pkg::*;
#(
  parameter int NF = 2,
  parameter int FW = 1
) (
  input logic                 clk,
  input logic                 rst_cold,
  input logic                 rst_warm,
  input logic                 bus_req,
  input logic                 bus_we,
  input logic [FW-1:0]        bus_func,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic [FW-1:0]        hw_func,
  input logic [EVT_W-1:0]     hw_evt,
  input logic [ROUTE_W-1:0]   route_q,
  input logic [NF-1:0]        pme_en_vec,
  input logic [NF*EVT_W-1:0]  evt_flat
);
  logic mapped;
  assign mapped = (bus_addr == OFS_IDENT) || (bus_addr == OFS_CTRL) ||
                  (bus_addr == OFS_EVT)   || (bus_addr == OFS_ROUTE) ||
                  (bus_addr == OFS_PM);

  a_r5_cold_clears: assert property (@(posedge clk)
    rst_cold |=> (route_q == '0) && (pme_en_vec == '0) && (evt_flat == '0));

  a_r8_route_survives_warm: assert property (@(posedge clk) disable iff (rst_cold)
    rst_warm |=> $stable(route_q));

  a_r9_func1_no_route_write: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
    (bus_req && bus_we && bus_func != '0) |=> $stable(route_q));

  a_r10_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
    (bus_req && !bus_we && !mapped) |=> (bus_rdata == '0));

  for (genvar i = 0; i < NF; i++) begin : g_f
    a_r7_ctx_kept: assert property (@(posedge clk) disable iff (rst_cold)
      (rst_warm && pme_en_vec[i]) |=> pme_en_vec[i] && $stable(evt_flat[i*EVT_W +: EVT_W]));

    a_r7_ctx_cleared: assert property (@(posedge clk) disable iff (rst_cold)
      (rst_warm && !pme_en_vec[i]) |=> (evt_flat[i*EVT_W +: EVT_W] == '0));

    a_r4_hw_set_wins: assert property (@(posedge clk) disable iff (rst_cold || rst_warm)
      (hw_func == FW'(i) && hw_evt != '0) |=>
        ((evt_flat[i*EVT_W +: EVT_W] & $past(hw_evt)) == $past(hw_evt)));
  end
endmodule

bind cfgrf_dualreset cfgrf_chk #(.NF(NUM_FUNC), .FW(FUNC_W)) u_chk (
  .clk(clk), .rst_cold(rst_cold), .rst_warm(rst_warm),
  .bus_req(bus_req), .bus_we(bus_we), .bus_func(bus_func), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .hw_func(hw_func), .hw_evt(hw_evt),
  .route_q(route_q), .pme_en_vec(pme_en_vec), .evt_flat(evt_flat));

// File: tb/sim_cfgrf_dualreset.sv
`timescale 1ns/1ps
module sim_cfgrf_dualreset;
  localparam real CLK_NS = 4.0;
  localparam logic [31:0] ID = 32'h7A10_0000;
  localparam logic [5:0] A_ID = 6'h00, A_CTRL = 6'h01, A_EVT = 6'h02,
                         A_ROUTE = 6'h03, A_PM = 6'h29;

  logic clk = 1'b0;
  logic rst_cold = 1'b1, rst_warm = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [0:0] bus_func = '0, hw_func = '0;
  logic [5:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0] hw_evt = '0;
  logic hw_pme = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  cfgrf_dualreset u0 (
    .clk(clk), .rst_cold(rst_cold), .rst_warm(rst_warm),
    .bus_req(bus_req), .bus_we(bus_we), .bus_func(bus_func), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_func(hw_func), .hw_evt(hw_evt), .hw_pme(hw_pme));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic f, input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_func = f; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd_chk(input string req, input logic f, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_func = f; bus_addr = a;
    @(negedge clk);
    bus_req = 0;
    chk(req, bus_rdata, exp);
  endtask

  task automatic hw(input logic f, input logic [7:0] e, input logic p);
    @(negedge clk);
    hw_func = f; hw_evt = e; hw_pme = p;
    @(negedge clk);
    hw_evt = '0; hw_pme = 0;
  endtask

  task automatic pulse_warm();
    @(negedge clk); rst_warm = 1;
    @(negedge clk); rst_warm = 0;
  endtask

  task automatic pulse_cold();
    @(negedge clk); rst_cold = 1;
    @(negedge clk); rst_cold = 0;
  endtask

  task automatic t_reset();
    rd_chk("R5 ctrl after cold", 0, A_CTRL, 32'h0);
    rd_chk("R5 pm after cold", 0, A_PM, 32'h0);
    rd_chk("R5 route after cold", 0, A_ROUTE, 32'h0);
    rd_chk("R5 f1 evt after cold", 1, A_EVT, 32'h0);
    rd_chk("R1 ident f0", 0, A_ID, ID);
    rd_chk("R1 ident f1", 1, A_ID, ID | 32'h1);
  endtask

  task automatic t_ident();
    wr(0, A_ID, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R1 ident ignores write", 0, A_ID, ID);
  endtask

  task automatic t_bytes();
    wr(0, A_CTRL, 4'b0001, 32'h1234_5678);
    rd_chk("R2 low byte only", 0, A_CTRL, 32'h0000_0078);
    wr(0, A_CTRL, 4'b0011, 32'h0000_AABB);
    rd_chk("R2 two bytes", 0, A_CTRL, 32'h0000_AABB);
    wr(0, A_CTRL, 4'b1100, 32'hFFFF_FFFF);
    rd_chk("R2 upper bytes unmapped", 0, A_CTRL, 32'h0000_AABB);
    rd_chk("R2 f1 untouched", 1, A_CTRL, 32'h0);
  endtask

  task automatic t_set();
    wr(0, A_EVT, 4'hF, 32'h0005_0000);
    rd_chk("R3 set bits", 0, A_EVT, 32'h0005_0000);
    wr(0, A_EVT, 4'hF, 32'h0002_0000);
    rd_chk("R3 set accumulates", 0, A_EVT, 32'h0007_0000);
    wr(0, A_EVT, 4'hF, 32'h0);
    rd_chk("R3 zero no effect", 0, A_EVT, 32'h0007_0000);
    wr(0, A_EVT, 4'b0011, 32'h00FF_0000);
    rd_chk("R3 byte disabled", 0, A_EVT, 32'h0007_0000);
  endtask

  task automatic t_clear();
    hw(0, 8'h81, 0);
    rd_chk("R4 hw set f0", 0, A_EVT, 32'h0007_0081);
    rd_chk("R4 f1 not hit", 1, A_EVT, 32'h0);
    wr(0, A_EVT, 4'hF, 32'h0000_0001);
    rd_chk("R4 w1c", 0, A_EVT, 32'h0007_0080);
    wr(0, A_EVT, 4'hF, 32'h0);
    rd_chk("R4 w0 no effect", 0, A_EVT, 32'h0007_0080);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_func = 0; bus_addr = A_EVT; bus_be = 4'hF;
    bus_wdata = 32'h0000_0080; hw_func = 0; hw_evt = 8'h80;
    @(negedge clk);
    bus_req = 0; bus_we = 0; hw_evt = '0;
    rd_chk("R4 hw set wins", 0, A_EVT, 32'h0007_0080);
    wr(0, A_EVT, 4'hF, 32'h0000_0080);
    rd_chk("R4 clear alone", 0, A_EVT, 32'h0007_0000);
    hw(0, 8'h80, 1);
    rd_chk("R4 pme status set", 0, A_PM, 32'h0000_8000);
  endtask

  task automatic t_warm_clear();
    wr(0, A_ROUTE, 4'hF, 32'h0000_1234);
    rd_chk("R9 route written", 0, A_ROUTE, 32'h0000_1234);
    pulse_warm();
    rd_chk("R6 ctrl cleared", 0, A_CTRL, 32'h0);
    rd_chk("R7 evt cleared enable 0", 0, A_EVT, 32'h0);
    rd_chk("R7 pm cleared enable 0", 0, A_PM, 32'h0);
    rd_chk("R8 route kept", 0, A_ROUTE, 32'h0000_1234);
  endtask

  task automatic t_warm_keep();
    wr(0, A_PM, 4'hF, 32'h0000_0103);
    rd_chk("R2 pm write", 0, A_PM, 32'h0000_0103);
    hw(0, 8'h10, 1);
    hw(1, 8'h02, 0);
    rd_chk("R4 f1 hw set", 1, A_EVT, 32'h0000_0002);
    wr(0, A_EVT, 4'hF, 32'h0003_0000);
    wr(0, A_CTRL, 4'hF, 32'h0000_0055);
    pulse_warm();
    rd_chk("R7 pm kept enable 1", 0, A_PM, 32'h0000_8100);
    rd_chk("R7 evt kept, R6 set bits cleared", 0, A_EVT, 32'h0000_0010);
    rd_chk("R6 ctrl cleared", 0, A_CTRL, 32'h0);
    rd_chk("R7 f1 evt cleared", 1, A_EVT, 32'h0);
    rd_chk("R8 route kept", 1, A_ROUTE, 32'h0000_1234);
  endtask

  task automatic t_global();
    wr(1, A_ROUTE, 4'hF, 32'h0000_BEEF);
    rd_chk("R9 f1 write ignored", 0, A_ROUTE, 32'h0000_1234);
    rd_chk("R9 f1 reads shared", 1, A_ROUTE, 32'h0000_1234);
    wr(0, A_ROUTE, 4'b0001, 32'h0000_00CD);
    rd_chk("R9 f0 write", 0, A_ROUTE, 32'h0000_12CD);
    rd_chk("R9 f1 sees f0 write", 1, A_ROUTE, 32'h0000_12CD);
  endtask

  task automatic t_unmapped();
    wr(0, A_CTRL, 4'hF, 32'h0000_0011);
    wr(0, 6'h10, 4'hF, 32'hFFFF_FFFF);
    rd_chk("R10 unmapped read", 0, 6'h10, 32'h0);
    rd_chk("R10 top address", 1, 6'h3F, 32'h0);
    rd_chk("R10 no alias write", 0, A_CTRL, 32'h0000_0011);
  endtask

  task automatic t_reset_block();
    @(negedge clk);
    rst_warm = 1; bus_req = 1; bus_we = 1; bus_func = 0;
    bus_addr = A_ROUTE; bus_be = 4'hF; bus_wdata = 32'h0000_FFFF;
    @(negedge clk);
    rst_warm = 0; bus_req = 0; bus_we = 0;
    rd_chk("R11 route write in warm", 0, A_ROUTE, 32'h0000_12CD);
    @(negedge clk);
    rst_warm = 1; bus_req = 1; bus_we = 1; bus_addr = A_PM; bus_wdata = 32'h0;
    @(negedge clk);
    rst_warm = 0; bus_req = 0; bus_we = 0;
    rd_chk("R11 pm write in warm", 0, A_PM, 32'h0000_8100);
  endtask

  task automatic t_cold();
    pulse_cold();
    rd_chk("R5 pm cold", 0, A_PM, 32'h0);
    rd_chk("R5 evt cold", 0, A_EVT, 32'h0);
    rd_chk("R5 route cold", 1, A_ROUTE, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_cold = 0;
    t_reset();
    t_ident();
    t_bytes();
    t_set();
    t_clear();
    t_warm_clear();
    t_warm_keep();
    t_global();
    t_unmapped();
    t_reset_block();
    t_cold();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule